// File: doc/BRIEF.md
# Sub-Sample Binned Pulse Accumulator

This block builds one finely resolved, averaged pulse shape from many pulses that were each captured at the coarse converter rate. Every ADC sample period is divided into 256 sub-bins. An upstream stage hands over one pulse at a time. Each pulse arrives as a sub-interval phase (0 to 255) and a fixed number of already normalised samples. The block adds sample k of the pulse into bin `k*256 + phase` of a sum memory and counts the hit in a matching count memory. Each update is a three-step read, add and write-back.

When the configured number of pulses has been taken in, the block turns every bin sum into a mean by dividing it by that bin's own count. It then smooths the resulting curve with a 49-tap centred boxcar, in which the division by 49 is a multiply by a fixed-point reciprocal. The smoothed curve goes into an output memory, which the user reads through a combinational read port. The input is a valid/ready handshake. A pulse offered while the block is busy is simply not taken, and upstream may discard it.

Top module: `subbin_pulse_avg`

## Requirements
- R1: While reset is low, and for the BINS = PULSE_LEN*256 clock cycles after it is released, `in_ready` and `done` are low while the memories are zeroed. `in_ready` is first high after exactly BINS rising edges.
- R2: A pulse is taken at a rising edge with `in_valid` and `in_ready` both high. `in_ready` is then low for exactly 3*PULSE_LEN cycles, which is three cycles per sample. `in_valid` is ignored while `in_ready` is low and changes no bin.
- R3: Sample k of a taken pulse lies in `in_samples[k*SAMPLE_W +: SAMPLE_W]`, as an unsigned value. It is added to the sum of bin k*256 + `in_phase`, and that bin's count goes up by one.
- R4: After NUM_PULSES pulses have been taken, `in_ready` never rises again and no further pulse is accepted.
- R5: Each bin's mean is floor(sum/count). A bin whose count is zero has a mean of zero.
- R6: Smoothed bin i is built from the window sum S, which is the total of the means at indices i-24 to i+24. An index below 0 is replaced by 0, and an index above BINS-1 is replaced by BINS-1.
- R7: The smoothed value equals (S*RC + 2^(F-1)) >> F, with F = RECIP_F and RC = floor((2^F + 24)/49).
- R8: `done` rises once every smoothed bin has been written, and it stays high until reset. While it is high, `ref_rd_data` shows the smoothed bin selected by `ref_rd_addr`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pulse is offered |
| in_ready | output | 1 | The block can take a pulse this cycle |
| in_phase | input | 8 | Sub-interval phase of the pulse start |
| in_samples | input | PULSE_LEN*SAMPLE_W | Normalised samples, sample 0 in the low bits |
| done | output | 1 | The smoothed curve is complete |
| ref_rd_addr | input | IDX_W | Read address into the smoothed curve |
| ref_rd_data | output | SAMPLE_W | Smoothed value at `ref_rd_addr` |

## Verification
The assertions watch the handshake on every cycle. They check that a taken pulse drops `in_ready` at once and keeps it low over the following cycles, and that the number of accepted pulses never exceeds the limit. They also check that `done` is reached only after exactly that many pulses, that it then stays high, and that the input stays closed once it is set. The placement of samples by phase, the per-bin division (including empty bins), the clamping at both ends of the array and the reciprocal rounding can only be shown by the bench. The bench feeds pulses at phase 0, phase 255 and phases in between, repeats some phases, and offers pulses while the block is busy. It then compares every smoothed bin with a model.

// File: rtl/subbin_pulse_avg.sv
module subbin_pulse_avg #(
  parameter int SAMPLE_W   = 12,
  parameter int PULSE_LEN  = 8,
  parameter int NUM_PULSES = 8192,
  parameter int RECIP_F    = 16,
  localparam int PHASE_BITS = 8,
  localparam int BINS       = PULSE_LEN << PHASE_BITS,
  localparam int IDX_W      = $clog2(BINS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PHASE_BITS-1:0]         in_phase,
  input  logic [PULSE_LEN*SAMPLE_W-1:0] in_samples,
  output logic                          done,
  input  logic [IDX_W-1:0]              ref_rd_addr,
  output logic [SAMPLE_W-1:0]           ref_rd_data
);
  localparam int K_W    = $clog2(PULSE_LEN + 1);
  localparam int CNT_W  = $clog2(NUM_PULSES + 1);
  localparam int SUM_W  = SAMPLE_W + CNT_W;
  localparam int S_W    = $clog2(SUM_W + 1);
  localparam int WSUM_W = SAMPLE_W + 6;
  localparam int PROD_W = WSUM_W + RECIP_F;
  localparam int RECIP  = ((1 << RECIP_F) + 24) / 49;

  typedef enum logic [3:0] {
    S_CLR, S_IDLE, S_RD, S_ADD, S_WR, S_DLOAD, S_DRUN, S_DWR, S_SMOOTH, S_DONE
  } state_t;

  state_t state;

  logic [SUM_W-1:0]    sum_mem [BINS];
  logic [CNT_W-1:0]    cnt_mem [BINS];
  logic [SAMPLE_W-1:0] ref_mem [BINS];

  logic [IDX_W-1:0]              bin_q;
  logic [K_W-1:0]                k_q;
  logic [PHASE_BITS-1:0]         phase_q;
  logic [PULSE_LEN*SAMPLE_W-1:0] smp_q;
  logic [CNT_W-1:0]              pulses_q;
  logic [SUM_W-1:0]              rd_sum, new_sum, quo;
  logic [CNT_W-1:0]              rd_cnt, new_cnt, div_q, rem;
  logic [S_W-1:0]                step_q;
  logic [5:0]                    tap_q;
  logic [WSUM_W-1:0]             wacc;

  logic [IDX_W-1:0]        acc_addr;
  logic [SAMPLE_W-1:0]     cur_sample;
  logic [CNT_W:0]          trial;
  logic signed [IDX_W+1:0] tap_pos;
  logic [IDX_W-1:0]        rd_idx;
  logic [WSUM_W-1:0]       wsum_next;
  logic [PROD_W-1:0]       prod;
  logic [SAMPLE_W-1:0]     scaled;
  logic                    last_bin;

  assign in_ready    = (state == S_IDLE);
  assign done        = (state == S_DONE);
  assign ref_rd_data = ref_mem[ref_rd_addr];

  assign acc_addr   = IDX_W'({k_q, phase_q});
  assign cur_sample = smp_q[k_q*SAMPLE_W +: SAMPLE_W];
  assign trial      = {rem, quo[SUM_W-1]};
  assign last_bin   = (bin_q == IDX_W'(BINS - 1));

  assign tap_pos = $signed({2'b00, bin_q}) + $signed((IDX_W+2)'(tap_q)) - $signed((IDX_W+2)'(24));
  always_comb begin
    if (tap_pos < 0)
      rd_idx = '0;
    else if (tap_pos > $signed((IDX_W+2)'(BINS - 1)))
      rd_idx = IDX_W'(BINS - 1);
    else
      rd_idx = tap_pos[IDX_W-1:0];
  end
  assign wsum_next = wacc + WSUM_W'(SAMPLE_W'(sum_mem[rd_idx]));
  assign prod      = PROD_W'(wsum_next) * PROD_W'(RECIP) + PROD_W'(1 << (RECIP_F - 1));
  assign scaled    = SAMPLE_W'(prod >> RECIP_F);

  always_ff @(posedge clk) begin
    case (state)
      S_CLR: begin
        sum_mem[bin_q] <= '0;
        cnt_mem[bin_q] <= '0;
      end
      S_WR: begin
        sum_mem[acc_addr] <= new_sum;
        cnt_mem[acc_addr] <= new_cnt;
      end
      S_DWR:    sum_mem[bin_q] <= quo;
      S_SMOOTH: if (tap_q == 6'd48) ref_mem[bin_q] <= scaled;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_CLR;
      bin_q    <= '0;
      k_q      <= '0;
      phase_q  <= '0;
      smp_q    <= '0;
      pulses_q <= '0;
      rd_sum   <= '0;
      rd_cnt   <= '0;
      new_sum  <= '0;
      new_cnt  <= '0;
      quo      <= '0;
      div_q    <= '0;
      rem      <= '0;
      step_q   <= '0;
      tap_q    <= '0;
      wacc     <= '0;
    end else begin
      case (state)
        S_CLR: begin
          bin_q <= last_bin ? '0 : bin_q + 1'b1;
          if (last_bin) state <= S_IDLE;
        end
        S_IDLE: if (in_valid) begin
          phase_q <= in_phase;
          smp_q   <= in_samples;
          k_q     <= '0;
          state   <= S_RD;
        end
        S_RD: begin
          rd_sum <= sum_mem[acc_addr];
          rd_cnt <= cnt_mem[acc_addr];
          state  <= S_ADD;
        end
        S_ADD: begin
          new_sum <= rd_sum + SUM_W'(cur_sample);
          new_cnt <= rd_cnt + CNT_W'(1);
          state   <= S_WR;
        end
        S_WR: begin
          if (k_q == K_W'(PULSE_LEN - 1)) begin
            pulses_q <= pulses_q + 1'b1;
            state    <= (pulses_q == CNT_W'(NUM_PULSES - 1)) ? S_DLOAD : S_IDLE;
          end else begin
            k_q   <= k_q + 1'b1;
            state <= S_RD;
          end
        end
        S_DLOAD: begin
          quo    <= sum_mem[bin_q];
          div_q  <= cnt_mem[bin_q];
          rem    <= '0;
          step_q <= '0;
          if (cnt_mem[bin_q] != '0) begin
            state <= S_DRUN;
          end else begin
            bin_q <= last_bin ? '0 : bin_q + 1'b1;
            state <= last_bin ? S_SMOOTH : S_DLOAD;
          end
        end
        S_DRUN: begin
          if (trial >= {1'b0, div_q}) begin
            rem <= CNT_W'(trial - {1'b0, div_q});
            quo <= {quo[SUM_W-2:0], 1'b1};
          end else begin
            rem <= CNT_W'(trial);
            quo <= {quo[SUM_W-2:0], 1'b0};
          end
          step_q <= step_q + 1'b1;
          if (step_q == S_W'(SUM_W - 1)) state <= S_DWR;
        end
        S_DWR: begin
          bin_q <= last_bin ? '0 : bin_q + 1'b1;
          state <= last_bin ? S_SMOOTH : S_DLOAD;
        end
        S_SMOOTH: begin
          if (tap_q == 6'd48) begin
            tap_q <= '0;
            wacc  <= '0;
            bin_q <= last_bin ? '0 : bin_q + 1'b1;
            if (last_bin) state <= S_DONE;
          end else begin
            tap_q <= tap_q + 1'b1;
            wacc  <= wsum_next;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module subbin_pulse_avg_chk #(
  parameter int NUM_PULSES = 8192
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic done
);
  localparam int N_W = $clog2(NUM_PULSES + 2);
  logic [N_W-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken <= '0;
    else if (in_valid && in_ready) taken <= taken + 1'b1;
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 2) |-> !in_ready); // R2
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    taken <= N_W'(NUM_PULSES)); // R4
  AST_CLOSED_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready); // R4
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (taken == N_W'(NUM_PULSES))); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
endmodule

bind subbin_pulse_avg subbin_pulse_avg_chk #(.NUM_PULSES(NUM_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .done(done)
);

// File: tb/subbin_pulse_avg_tb.sv
module subbin_pulse_avg_tb;
  localparam int SW = 12;
  localparam int PL = 2;
  localparam int NP = 6;
  localparam int RF = 16;
  localparam int BINS = PL * 256;
  localparam int IW = $clog2(BINS);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_phase = '0;
  logic [PL*SW-1:0] in_samples = '0;
  logic [IW-1:0] ref_rd_addr = '0;
  logic in_ready, done;
  logic [SW-1:0] ref_rd_data;

  int checks = 0;
  int errors = 0;
  int m_sum [BINS];
  int m_cnt [BINS];
  int exp_q [$];
  bit pushed_all = 0;

  always #2 clk = ~clk;

  subbin_pulse_avg #(.SAMPLE_W(SW), .PULSE_LEN(PL), .NUM_PULSES(NP), .RECIP_F(RF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_samples(in_samples), .done(done),
    .ref_rd_addr(ref_rd_addr), .ref_rd_data(ref_rd_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: offers a pulse, optionally offers a junk pulse while busy (R2)
  task automatic send_pulse(input int ph, input int s0, input int s1, input bit junk, input bit last);
    int n;
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_phase = 8'(ph);
    in_samples = {SW'(s1), SW'(s0)};
    @(posedge clk); @(negedge clk);
    m_sum[ph] += s0; m_cnt[ph] += 1;          // R3 bin k*256+phase
    m_sum[256 + ph] += s1; m_cnt[256 + ph] += 1;
    check(in_ready == 0, "R2 ready drop", in_ready, 0);
    if (junk) begin in_phase = 8'd10; in_samples = {SW'(3000), SW'(3000)}; end
    else in_valid = 0;
    n = 0;
    while (n < 3 * PL + 4) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (n == 3) in_valid = 0;
      if (in_ready) break;
    end
    if (last) check(in_ready == 0, "R4 no ready after last pulse", in_ready, 0);
    else check(n == 3 * PL, "R2 busy length", n, 3 * PL);
  endtask

  function automatic int avg_of(input int j);
    if (j < 0) j = 0;
    if (j > BINS - 1) j = BINS - 1;
    return (m_cnt[j] == 0) ? 0 : m_sum[j] / m_cnt[j];   // R5
  endfunction

  task automatic push_expected();
    longint rc, s;
    rc = ((longint'(1) << RF) + 24) / 49;              // R7 reciprocal
    for (int i = 0; i < BINS; i++) begin
      s = 0;
      for (int t = -24; t <= 24; t++) s += avg_of(i + t); // R6 clamped window
      exp_q.push_back(int'((s * rc + (longint'(1) << (RF - 1))) >> RF));
    end
    pushed_all = 1;
  endtask

  // Monitor: pops expected smoothed bins and compares the read port (R8)
  initial begin
    int addr;
    int e;
    addr = 0;
    wait (done);
    forever begin
      while (exp_q.size() == 0) @(negedge clk);
      e = exp_q.pop_front();
      @(negedge clk);
      ref_rd_addr = IW'(addr);
      #1;
      if (addr < 24 || addr >= BINS - 24)
        check(ref_rd_data == SW'(e), "R6 R7 R8 edge bin", ref_rd_data, e);
      else
        check(ref_rd_data == SW'(e), "R3 R5 R7 R8 bin", ref_rd_data, e);
      addr++;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    check(0, "watchdog", wd, 0);
    finish_run();
  end

  initial begin
    int n;
    foreach (m_sum[i]) begin m_sum[i] = 0; m_cnt[i] = 0; end
    #1;
    check(in_ready == 0 && done == 0, "R1 reset state", {in_ready, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!in_ready && n < BINS + 10);
    check(n == BINS, "R1 clear length", n, BINS);
    check(done == 0, "R1 done low", done, 0);
    send_pulse(0, 100, 2000, 0, 0);
    send_pulse(0, 103, 1500, 1, 0);
    send_pulse(255, 4095, 4000, 0, 0);
    send_pulse(128, 7, 9, 1, 0);
    send_pulse(255, 1, 3, 0, 0);
    send_pulse(37, 0, 4095, 0, 1);
    in_valid = 1; in_phase = 8'd50; in_samples = {SW'(4000), SW'(4000)};
    repeat (5) begin
      @(posedge clk); @(negedge clk);
      check(in_ready == 0, "R4 closed after limit", in_ready, 0);
    end
    in_valid = 0;
    wait (done);
    @(negedge clk);
    check(in_ready == 0, "R4 closed when done", in_ready, 0);
    push_expected();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done == 1, "R8 done held", done, 1);
    finish_run();
  end
endmodule